// File: doc/BRIEF.md
# Frame-Master Serial Payload Input

This block is the transmit-side payload entry point of an E3 framer that runs with local timing and owns the frame timing itself. A single transmit clock times everything. Each rising edge of that clock latches one payload bit from the terminal equipment's serial data pin. One bit period is one clock cycle, nominally at 34.368 MHz.

A free-running bit counter starts at bit 0 when reset is released. It wraps at the end of each frame without any gap, and it follows no external frame signal. While the counter sits on the final bit of a frame, the block raises a strobe for that one cycle. The terminal equipment watches the strobe and puts the first bit of the next frame on the pin in the following cycle. The block tags every latched bit with its position in the frame and passes it on to the downstream frame assembler.

Top module: `frm_serial_in`

## Requirements
- R1: While rst_ni is low, and right after it is released, frm_last_o is 0, frm_start_o is 1 (the counter is on bit 0) and pay_vld_o is 0.
- R2: The bit counter advances by exactly one each clock cycle. This is visible as consecutive pay_idx_o values that step by one.
- R3: frm_last_o is high for exactly one cycle in every FRAME_BITS cycles, and never in two consecutive cycles.
- R4: After reset release, the first frm_last_o pulse comes in cycle FRAME_BITS-1. Cycle 0 is the cycle in which reset is released, and each rising edge starts a new cycle.
- R5: frm_start_o is high in the cycle directly after every frm_last_o pulse, and in no other cycle except the reset cycle 0.
- R6: The value on ser_i at a rising edge of clk_i appears on pay_bit_o after that edge, with pay_vld_o = 1, and is held for one cycle.
- R7: The bit on ser_i during the cycle after a frm_last_o pulse is reported with pay_idx_o = 0. In general, a bit latched at the edge that ends cycle k carries index k mod FRAME_BITS.
- R8: After index FRAME_BITS-1, the next valid sample has index 0, with no idle cycle in between.
- R9: The values on ser_i have no effect on frm_last_o, frm_start_o or pay_idx_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit input clock, one bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial payload from terminal equipment |
| frm_last_o | output | 1 | High during the last bit period of a frame |
| frm_start_o | output | 1 | High during the first bit period of a frame |
| pay_vld_o | output | 1 | pay_bit_o and pay_idx_o carry a latched bit |
| pay_bit_o | output | 1 | Latched payload bit |
| pay_idx_o | output | $clog2(FRAME_BITS) | Frame position of pay_bit_o |

## Verification
frm_last_o and frm_start_o are combinational from the counter. They are due in the same cycle the counter reaches the last or the first bit, so the bench checks them in the cycle number the requirements give. pay_bit_o, pay_idx_o and pay_vld_o are due one edge after the bit is on ser_i, so the bench compares them with the bit it drove one cycle earlier and that cycle's index. All outputs are sampled on the falling edge, and a second, asynchronous reset in mid-frame restarts the cycle count.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic [1:0] {
    PH_BODY  = 2'd0,
    PH_FIRST = 2'd1,
    PH_LAST  = 2'd2
  } frm_phase_e;

  typedef struct packed {
    logic vld;
    logic dat;
  } pay_bit_t;
endpackage

// File: rtl/frm_bit_ctr.sv
module frm_bit_ctr
  import frm_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 1536,
  localparam int unsigned IDX_W = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] idx_o,
  output frm_phase_e       phase_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cnt_q == LAST_IDX) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (cnt_q == LAST_IDX)  phase_o = PH_LAST;
    else if (cnt_q == '0)   phase_o = PH_FIRST;
    else                    phase_o = PH_BODY;
  end

  assign idx_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != PH_LAST) |=> (idx_o == $past(idx_o) + 1'b1)); // R2
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_LAST) |=> (phase_o == PH_FIRST)); // R8
endmodule

// File: rtl/frm_capture.sv
module frm_capture
  import frm_pkg::*;
#(
  parameter int unsigned IDX_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic [IDX_W-1:0] idx_i,
  output pay_bit_t         pay_o,
  output logic [IDX_W-1:0] idx_o
);
  pay_bit_t         pay_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pay_q <= '0;
      idx_q <= '0;
    end else begin
      pay_q <= '{vld: 1'b1, dat: ser_i};
      idx_q <= idx_i;
    end
  end

  assign pay_o = pay_q;
  assign idx_o = idx_q;

  AST_CAP_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_o.vld |=> (pay_o.vld && pay_o.dat == $past(ser_i))); // R6
  AST_CAP_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_o.vld && idx_i != '0) |=> (idx_o == $past(idx_o) + 1'b1)); // R7
endmodule

// File: rtl/frm_serial_in.sv
module frm_serial_in
  import frm_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 1536,
  localparam int unsigned IDX_W = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  output logic             frm_last_o,
  output logic             frm_start_o,
  output logic             pay_vld_o,
  output logic             pay_bit_o,
  output logic [IDX_W-1:0] pay_idx_o
);
  logic [IDX_W-1:0] cur_idx;
  frm_phase_e       phase;
  pay_bit_t         pay;

  frm_bit_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_o   (cur_idx),
    .phase_o (phase)
  );

  frm_capture #(.IDX_W(IDX_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ser_i  (ser_i),
    .idx_i  (cur_idx),
    .pay_o  (pay),
    .idx_o  (pay_idx_o)
  );

  assign frm_last_o  = (phase == PH_LAST);
  assign frm_start_o = (phase == PH_FIRST);
  assign pay_vld_o   = pay.vld;
  assign pay_bit_o   = pay.dat;

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_last_o |=> !frm_last_o); // R3
  AST_START_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_last_o |=> frm_start_o); // R5
  AST_FIRST_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_start_o |=> (pay_vld_o && pay_idx_o == '0)); // R7
endmodule

// File: tb/frm_serial_in_tb.sv
module frm_serial_in_tb_top;
  localparam int N = 12;
  localparam int IW = $clog2(N);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ser = 1'b0;
  logic last_w, start_w, vld_w, bit_w;
  logic [IW-1:0] idx_w;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit hist[$];
  logic [7:0] lfsr = 8'hA5;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frm_serial_in #(.FRAME_BITS(N)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ser_i       (ser),
    .frm_last_o  (last_w),
    .frm_start_o (start_w),
    .pay_vld_o   (vld_w),
    .pay_bit_o   (bit_w),
    .pay_idx_o   (idx_w)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic chk_reset();
    chk("R1 last", int'(last_w), 0);
    chk("R1 start", int'(start_w), 1);
    chk("R1 vld", int'(vld_w), 0);
  endtask

  // model: cycle cyc counts rising edges since reset release
  task automatic chk_cycle();
    chk(cyc < N ? "R4 last" : "R3 R9 last", int'(last_w), int'(cyc % N == N-1));
    chk("R5 R9 start", int'(start_w), int'(cyc % N == 0));
    if (cyc == 0) begin
      chk("R1 vld", int'(vld_w), 0);
    end else begin
      chk("R6 vld", int'(vld_w), 1);
      chk("R6 data", int'(bit_w), int'(hist[cyc-1]));
      chk(((cyc-1) % N == 0) ? "R7 R8 idx" : "R2 R9 idx", int'(idx_w), (cyc-1) % N);
    end
  endtask

  task automatic run(int cycles, int mode);
    for (int i = 0; i < cycles; i++) begin
      chk_cycle();
      case (mode)
        0: ser = 1'b0;
        1: ser = 1'b1;
        2: ser = cyc[0];
        default: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          ser = lfsr[0];
        end
      endcase
      hist.push_back(ser);
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk_reset();
    repeat (2) @(negedge clk);
    chk_reset();
    rst_ni = 1'b1;
    #1;
    chk_reset();
    cyc = 0;
    hist.delete();
  endtask

  initial begin
    do_reset();
    run(3 * N, 0);
    run(2 * N, 1);
    run(2 * N + 5, 2);
    do_reset();
    run(4 * N + 3, 3);
    do_reset();
    run(3 * N, 3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule